// File: doc/BRIEF.md
# Internal Data Space Access Unit

This block holds the on-chip data space of a small 8-bit controller core: 256 bytes of RAM, the working-register window, the stack pointer and a small set of special-function registers (accumulator, B, status word, two port latches). A core issues one command per clock on an opcode-style interface. Each accepted command completes in one cycle. After that edge the block presents the byte it fetched and the updated accumulator.

The block's defining property is that the upper half of the address range (0x80 to 0xFF) names two different stores. Direct addressing reaches the special-function registers there. Pointer addressing through a working register reaches a separate block of upper RAM. Stack commands move bytes between RAM at the stack pointer and a directly addressed location. They follow a fixed order for the stack pointer update. Two exchange commands swap data with the accumulator: one swaps the whole byte, the other swaps only the low nibble.

Top module: `idata_unit`

## Requirements
- R1: A command is sampled on a rising clock edge when `cmd_valid` is 1. `cmd_op` encodes it as follows: 0 none, 1 direct read, 2 direct write, 3 pointer read, 4 pointer write, 5 push, 6 pop, 7 exchange with a direct byte, 8 exchange with a pointed byte, 9 low-nibble exchange with a pointed byte, 10 exchange with a working register, 11 load accumulator from `cmd_wdata`. After that edge, `rsp_valid` is 1 and `rsp_data` holds the addressed byte as it was before the command. For opcode 11, `rsp_data` holds the previous accumulator. With `cmd_valid` at 0, or with opcode 0 or 12 to 15, no state changes, `rsp_valid` is 0 and `rsp_data` keeps its value.
- R2: After reset, `rsp_valid` is 0, the accumulator is 0x00, the stack pointer is 0x07, all RAM and the B and status registers are 0x00, and both port latches are 0xFF.
- R3: Direct addresses 0x00 to 0x7F reach RAM. Direct addresses 0x80 to 0xFF reach the special-function registers: port 0 at 0x80, stack pointer at 0x81, port 1 at 0x90, status word at 0xD0, accumulator at 0xE0 and B at 0xF0. Any other upper address reads 0x00 and ignores writes.
- R4: Pointer commands use working register R0 or R1, selected by bit 0 of `cmd_addr`, as an 8-bit pointer into all 256 RAM bytes. A pointer at 0x80 or above reaches upper RAM and never a special-function register.
- R5: Status word bits [4:3] select the register bank. Working register Rn sits at RAM address bank*8+n. This holds for pointer selection and for the register exchange, which takes n from `cmd_addr[2:0]`.
- R6: A push first increments the stack pointer. It then stores the directly addressed source byte in RAM at the new stack pointer.
- R7: A pop first reads RAM at the stack pointer and writes that byte to the directly addressed destination. It then decrements the stack pointer. When the destination is the stack pointer, the written byte wins.
- R8: The stack pointer wraps modulo 256: a push from 0xFF gives 0x00, and a pop from 0x00 gives 0xFF.
- R9: A full exchange swaps the accumulator and the addressed byte (direct, working register or pointed) in one command.
- R10: A nibble exchange swaps only bits [3:0] of the accumulator and of the pointed byte. Both upper nibbles stay unchanged.
- R11: A direct write or pop to address 0xE0 changes the same accumulator that opcode 11 loads. The result is visible on `acc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 8 | Direct address, register index or pointer select |
| cmd_wdata | input | 8 | Write data for write and load commands |
| rsp_valid | output | 1 | A command completed at the last edge |
| rsp_data | output | 8 | Byte read by the last completed command |
| acc_out | output | 8 | Current accumulator |
| sp_out | output | 8 | Current stack pointer |

## Verification
The assertions assume that `cmd_op` and `cmd_addr` are known whenever `cmd_valid` is high. They also assume that a pop whose destination is the stack pointer is the only case in which a stack command and a stack-pointer write coincide, which is why the decrement check excludes it. The stimulus always drives defined values and may issue any opcode, including undefined ones, against any address. A behavioural model in the bench follows the ordering rules above, including pops into the stack pointer and exchanges that target the accumulator's own address. It is compared after every clock.

// File: rtl/idata_pkg.sv
package idata_pkg;

  parameter int unsigned DW = 8;
  parameter int unsigned AW = 8;
  localparam int unsigned RAM_DEPTH = 1 << AW;
  localparam int unsigned NIB = DW / 2;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_DRD   = 4'd1,
    OP_DWR   = 4'd2,
    OP_IRD   = 4'd3,
    OP_IWR   = 4'd4,
    OP_PUSH  = 4'd5,
    OP_POP   = 4'd6,
    OP_XDIR  = 4'd7,
    OP_XIND  = 4'd8,
    OP_XNIB  = 4'd9,
    OP_XREG  = 4'd10,
    OP_ALOAD = 4'd11
  } op_e;

  localparam logic [AW-1:0] A_PORT0 = 8'h80;
  localparam logic [AW-1:0] A_STKP  = 8'h81;
  localparam logic [AW-1:0] A_PORT1 = 8'h90;
  localparam logic [AW-1:0] A_STAT  = 8'hD0;
  localparam logic [AW-1:0] A_ACCU  = 8'hE0;
  localparam logic [AW-1:0] A_BREG  = 8'hF0;

  localparam logic [DW-1:0] STKP_RESET = 8'h07;
  localparam logic [DW-1:0] PORT_RESET = 8'hFF;

  // Physical RAM address of working register n in bank b: b*8 + n.
  function automatic logic [AW-1:0] reg_phys(input logic [1:0] bank, input logic [2:0] n);
    return {{(AW-5){1'b0}}, bank, n};
  endfunction

  // Upper nibble from hi_src, lower nibble from lo_src.
  function automatic logic [DW-1:0] nib_merge(input logic [DW-1:0] hi_src,
                                              input logic [DW-1:0] lo_src);
    return {hi_src[DW-1:NIB], lo_src[NIB-1:0]};
  endfunction

  function automatic logic [DW-1:0] stk_step(input logic [DW-1:0] sp, input logic up);
    return up ? sp + 1'b1 : sp - 1'b1;
  endfunction

endpackage

// File: rtl/idata_ram.sv
module idata_ram
  import idata_pkg::*;
#(
  parameter int unsigned DEPTH = RAM_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);

  logic [DW-1:0] mem [DEPTH];

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Storage for every direct, pointer and stack write (R3, R4).
  assert_ram_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/idata_sfr.sv
module idata_sfr
  import idata_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_ld,
  input  logic [DW-1:0] acc_val,
  input  logic          sp_inc,
  input  logic          sp_dec,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] sp,
  output logic [1:0]    bank
);

  logic [DW-1:0] breg, stat, port0, port1;

  wire wr_sp  = wr_en && (wr_addr == A_STKP);
  wire wr_acc = wr_en && (wr_addr == A_ACCU);

  assign bank = stat[4:3];

  always_comb begin
    unique case (rd_addr)
      A_PORT0: rd_data = port0;
      A_STKP:  rd_data = sp;
      A_PORT1: rd_data = port1;
      A_STAT:  rd_data = stat;
      A_ACCU:  rd_data = acc;
      A_BREG:  rd_data = breg;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      breg  <= '0;
      stat  <= '0;
      sp    <= STKP_RESET;
      port0 <= PORT_RESET;
      port1 <= PORT_RESET;
    end else begin
      if (acc_ld)      acc <= acc_val;
      else if (wr_acc) acc <= wr_data;
      if (wr_sp)       sp <= wr_data;
      else if (sp_inc) sp <= stk_step(sp, 1'b1);
      else if (sp_dec) sp <= stk_step(sp, 1'b0);
      if (wr_en && wr_addr == A_BREG)  breg  <= wr_data;
      if (wr_en && wr_addr == A_STAT)  stat  <= wr_data;
      if (wr_en && wr_addr == A_PORT0) port0 <= wr_data;
      if (wr_en && wr_addr == A_PORT1) port1 <= wr_data;
    end
  end

  assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_inc |=> sp == $past(sp) + 8'd1);

  assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_dec && !wr_sp) |=> sp == $past(sp) - 8'd1);

  assert_acc_alias_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !acc_ld) |=> acc == $past(wr_data));

endmodule

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
(
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] sp,
  input  logic [1:0]    bank,
  input  logic [DW-1:0] ptr_val,
  input  logic [DW-1:0] rb_data,
  input  logic [DW-1:0] sfr_rdata,
  output logic [AW-1:0] ra_addr,
  output logic [AW-1:0] rb_addr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_waddr,
  output logic [DW-1:0] sfr_wdata,
  output logic          acc_ld,
  output logic [DW-1:0] acc_val,
  output logic          sp_inc,
  output logic          sp_dec,
  output logic          act,
  output logic [DW-1:0] old_byte
);

  logic [DW-1:0] dir_val;
  logic          upper;

  assign upper   = addr[AW-1];
  assign ra_addr = reg_phys(bank, {2'b00, addr[0]});
  assign dir_val = upper ? sfr_rdata : rb_data;

  // Port B address: pointer target, stack slot, bank register or direct address.
  always_comb begin
    unique case (op)
      OP_IRD, OP_IWR, OP_XIND, OP_XNIB: rb_addr = ptr_val;
      OP_POP:                           rb_addr = sp;
      OP_XREG:                          rb_addr = reg_phys(bank, addr[2:0]);
      default:                          rb_addr = addr;
    endcase
  end

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = rb_addr;
    ram_wdata = '0;
    sfr_we    = 1'b0;
    sfr_waddr = addr;
    sfr_wdata = '0;
    acc_ld    = 1'b0;
    acc_val   = '0;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    act       = 1'b1;
    old_byte  = rb_data;
    unique case (op)
      OP_DRD: old_byte = dir_val;
      OP_DWR: begin
        old_byte = dir_val;
        if (upper) begin sfr_we = 1'b1; sfr_wdata = wdata; end
        else begin ram_we = 1'b1; ram_waddr = addr; ram_wdata = wdata; end
      end
      OP_IRD: old_byte = rb_data;
      OP_IWR: begin
        ram_we    = 1'b1;
        ram_wdata = wdata;
      end
      OP_PUSH: begin
        old_byte  = dir_val;
        sp_inc    = 1'b1;
        ram_we    = 1'b1;
        ram_waddr = stk_step(sp, 1'b1);
        ram_wdata = dir_val;
      end
      OP_POP: begin
        sp_dec = 1'b1;
        if (upper) begin sfr_we = 1'b1; sfr_wdata = rb_data; end
        else begin ram_we = 1'b1; ram_waddr = addr; ram_wdata = rb_data; end
      end
      OP_XDIR: begin
        old_byte = dir_val;
        acc_ld   = 1'b1;
        acc_val  = dir_val;
        if (upper) begin sfr_we = 1'b1; sfr_wdata = acc; end
        else begin ram_we = 1'b1; ram_waddr = addr; ram_wdata = acc; end
      end
      OP_XIND, OP_XREG: begin
        acc_ld    = 1'b1;
        acc_val   = rb_data;
        ram_we    = 1'b1;
        ram_wdata = acc;
      end
      OP_XNIB: begin
        acc_ld    = 1'b1;
        acc_val   = nib_merge(acc, rb_data);
        ram_we    = 1'b1;
        ram_wdata = nib_merge(rb_data, acc);
      end
      OP_ALOAD: begin
        old_byte = acc;
        acc_ld   = 1'b1;
        acc_val  = wdata;
      end
      default: act = 1'b0;
    endcase
  end

  // One command reaches one store: RAM or the register file, never both (R3, R4).
  assert_one_store_R3: assert final ($onehot0({ram_we, sfr_we}));

endmodule

// File: rtl/idata_unit.sv
module idata_unit
  import idata_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] sp_out
);

  op_e           op_eff;
  logic [AW-1:0] ra_addr, rb_addr, ram_waddr, sfr_waddr;
  logic [DW-1:0] ra_data, rb_data, ram_wdata, sfr_wdata, sfr_rdata;
  logic [DW-1:0] acc_val, acc_q, sp_q, old_byte;
  logic          ram_we, sfr_we, acc_ld, sp_inc, sp_dec, act;
  logic [1:0]    bank;

  assign op_eff  = cmd_valid ? op_e'(cmd_op) : OP_NONE;
  assign acc_out = acc_q;
  assign sp_out  = sp_q;

  idata_decode i_decode (
    .op(op_eff), .addr(cmd_addr), .wdata(cmd_wdata), .acc(acc_q), .sp(sp_q),
    .bank(bank), .ptr_val(ra_data), .rb_data(rb_data), .sfr_rdata(sfr_rdata),
    .ra_addr(ra_addr), .rb_addr(rb_addr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .sfr_we(sfr_we), .sfr_waddr(sfr_waddr),
    .sfr_wdata(sfr_wdata), .acc_ld(acc_ld), .acc_val(acc_val), .sp_inc(sp_inc),
    .sp_dec(sp_dec), .act(act), .old_byte(old_byte)
  );

  idata_ram #(.DEPTH(RAM_DEPTH)) i_ram (
    .clk(clk), .rst_n(rst_n), .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data), .we(ram_we), .waddr(ram_waddr),
    .wdata(ram_wdata)
  );

  idata_sfr i_sfr (
    .clk(clk), .rst_n(rst_n), .rd_addr(cmd_addr), .rd_data(sfr_rdata),
    .wr_en(sfr_we), .wr_addr(sfr_waddr), .wr_data(sfr_wdata), .acc_ld(acc_ld),
    .acc_val(acc_val), .sp_inc(sp_inc), .sp_dec(sp_dec), .acc(acc_q),
    .sp(sp_q), .bank(bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= act;
      if (act) rsp_data <= old_byte;
    end
  end

  assert_nib_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_XNIB) |=> acc_out[DW-1:NIB] == $past(acc_out[DW-1:NIB]));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && $stable(acc_out) && $stable(sp_out));

endmodule

// File: tb/test_idata_unit.sv
module test_idata_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data, acc_out, sp_out;

  always #5 clk = ~clk;

  int checks = 0, fails = 0;

  // Behavioural reference state
  int  m_ram[256];
  int  m_acc, m_b, m_psw, m_sp, m_p0, m_p1, m_rsp;
  bit  m_vld;

  idata_unit i_idata_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .acc_out(acc_out), .sp_out(sp_out)
  );

  function automatic int dread(int a);
    if (a < 128) return m_ram[a];
    case (a)
      'h80: return m_p0;
      'h81: return m_sp;
      'h90: return m_p1;
      'hD0: return m_psw;
      'hE0: return m_acc;
      'hF0: return m_b;
      default: return 0;
    endcase
  endfunction

  function automatic void dwrite(int a, int v);
    if (a < 128) m_ram[a] = v;
    else case (a)
      'h80: m_p0 = v;
      'h81: m_sp = v;
      'h90: m_p1 = v;
      'hD0: m_psw = v;
      'hE0: m_acc = v;
      'hF0: m_b = v;
      default: ;
    endcase
  endfunction

  function automatic int regaddr(int n);
    return ((m_psw >> 3) & 3) * 8 + n;
  endfunction

  function automatic void model(bit v, int op, int a, int w);
    int p, m;
    if (!v || op == 0 || op > 11) begin m_vld = 0; return; end
    m_vld = 1;
    p = m_ram[regaddr(a & 1)];
    case (op)
      1: m_rsp = dread(a);
      2: begin m_rsp = dread(a); dwrite(a, w); end
      3: m_rsp = m_ram[p];
      4: begin m_rsp = m_ram[p]; m_ram[p] = w; end
      5: begin m = dread(a); m_rsp = m; m_sp = (m_sp + 1) % 256; m_ram[m_sp] = m; end
      6: begin m = m_ram[m_sp]; m_rsp = m; m_sp = (m_sp + 255) % 256; dwrite(a, m); end
      7: begin m = dread(a); m_rsp = m; dwrite(a, m_acc); m_acc = m; end
      8: begin m = m_ram[p]; m_rsp = m; m_ram[p] = m_acc; m_acc = m; end
      9: begin
        m = m_ram[p]; m_rsp = m;
        m_ram[p] = (m & 'hF0) | (m_acc & 'h0F);
        m_acc = (m_acc & 'hF0) | (m & 'h0F);
      end
      10: begin
        p = regaddr(a & 7); m = m_ram[p]; m_rsp = m;
        m_ram[p] = m_acc; m_acc = m;
      end
      11: begin m_rsp = m_acc; m_acc = w; end
      default: ;
    endcase
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rsp_valid !== m_vld || rsp_data !== 8'(m_rsp) ||
        acc_out !== 8'(m_acc) || sp_out !== 8'(m_sp)) begin
      fails++;
      $display("FAIL %s: got vld=%0b data=%02h acc=%02h sp=%02h, expected vld=%0b data=%02h acc=%02h sp=%02h",
               tag, rsp_valid, rsp_data, acc_out, sp_out, m_vld, 8'(m_rsp), 8'(m_acc), 8'(m_sp));
    end
  endtask

  task automatic run(bit v, int op, int a, int w, string tag);
    cmd_valid = v;
    cmd_op    = 4'(op);
    cmd_addr  = 8'(a);
    cmd_wdata = 8'(w);
    model(v, op, a, w);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (m_ram[i]) m_ram[i] = 0;
    m_acc = 0; m_b = 0; m_psw = 0; m_sp = 7; m_p0 = 'hFF; m_p1 = 'hFF;
    m_rsp = 0; m_vld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R2 reset state");

    // R3 direct RAM and register file
    run(1, 2, 'h30, 'h5A, "R3 write low RAM");
    run(1, 1, 'h30, 0,    "R3 read low RAM");
    run(1, 1, 'h80, 0,    "R2 port0 reset value");
    run(1, 2, 'h90, 'h3C, "R3 write port1");
    run(1, 1, 'h90, 0,    "R3 read port1");
    run(1, 2, 'hA5, 'h77, "R3 write unmapped");
    run(1, 1, 'hA5, 0,    "R3 unmapped reads zero");

    // R4 pointer reaches upper RAM, not registers
    run(1, 2, 'h00, 'h90, "R4 set R0 pointer");
    run(1, 4, 0, 'hC3,    "R4 pointer write upper RAM");
    run(1, 1, 'h90, 0,    "R4 port1 untouched");
    run(1, 3, 0, 0,       "R4 pointer read upper RAM");

    // R5 bank select
    run(1, 2, 'hD0, 'h08, "R5 select bank 1");
    run(1, 2, 'h08, 'h40, "R5 set bank1 R0");
    run(1, 4, 0, 'h11,    "R5 pointer via bank1 R0");
    run(1, 1, 'h40, 0,    "R5 read pointed byte");
    run(1, 2, 'h0B, 'hA7, "R5 set bank1 R3");

    // R11 accumulator alias
    run(1, 2, 'hE0, 'h9E, "R11 write acc by address");
    run(1, 11, 0, 'h21,   "R1 load accumulator");
    run(1, 1, 'hE0, 0,    "R11 read acc by address");

    // R6 / R7 stack
    run(1, 2, 'hF0, 'h66, "R3 write B");
    run(1, 5, 'hE0, 0,    "R6 push accumulator");
    run(1, 5, 'hF0, 0,    "R6 push B");
    run(1, 1, 'h09, 0,    "R6 pushed byte stored");
    run(1, 6, 'h31, 0,    "R7 pop into RAM");
    run(1, 6, 'hE0, 0,    "R7 pop into accumulator");
    run(1, 1, 'h31, 0,    "R7 popped byte stored");

    // R8 wrap
    run(1, 2, 'h81, 'hFF, "R8 set SP top");
    run(1, 5, 'h30, 0,    "R8 push wraps to 0");
    run(1, 6, 'h32, 0,    "R8 pop wraps to FF");
    run(1, 2, 'h81, 'h20, "R7 SP move");
    run(1, 6, 'h81, 0,    "R7 pop into SP wins");

    // R9 full exchanges
    run(1, 11, 0, 'h5C,   "R1 load accumulator");
    run(1, 7, 'h30, 0,    "R9 exchange direct");
    run(1, 1, 'h30, 0,    "R9 direct byte took acc");
    run(1, 10, 3, 0,      "R9 exchange bank1 R3");
    run(1, 2, 'h09, 'h50, "R5 set bank1 R1");
    run(1, 8, 1, 0,       "R9 exchange via R1");
    run(1, 7, 'hE0, 0,    "R9 exchange acc with itself");

    // R10 nibble exchange
    run(1, 11, 0, 'hB4,   "R1 load accumulator");
    run(1, 2, 'h50, 'h7E, "R10 prepare byte");
    run(1, 9, 1, 0,       "R10 nibble exchange");
    run(1, 1, 'h50, 0,    "R10 byte upper nibble kept");

    // R1 idle and invalid commands
    run(0, 5, 'hE0, 0,    "R1 valid low ignored");
    run(1, 0, 'h30, 0,    "R1 no-op");
    run(1, 15, 'h30, 'h00, "R1 undefined opcode");
    run(1, 1, 'h30, 0,    "R1 state kept");

    // Mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int op, a;
      op = int'($urandom_range(0, 13));
      case ($urandom_range(0, 3))
        0: a = int'($urandom_range(0, 15));
        1: a = int'($urandom_range(0, 255));
        2: a = ($urandom_range(0, 1) != 0) ? 'hE0 : 'hD0;
        default: a = ($urandom_range(0, 1) != 0) ? 'h81 : 'h90;
      endcase
      run($urandom_range(0, 7) != 0, op, a, int'($urandom_range(0, 255)), "R1 mixed traffic");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule